// File: doc/BRIEF.md
# External Interrupt Front End

This block sits between seven external interrupt sources and an 8051-style processor core. Every source is sampled through a synchronizer and watched for one edge direction. When that edge is seen, the source's pending flag is set. A request goes to the core only when the matching enable bit is also set. When the core acknowledges a request, it names the channel it is servicing, and that channel's flag clears on the next clock edge. The core's priority and vectoring logic are outside this block.

The sources are wired as follows.
- Channels 0 and 1 come from two digital I/O request lines.
- Channels 2 and 4 both watch the same comparator output. Channel 2 has a programmable edge direction, and software sets it to falling. Channel 4 reacts to rising edges only.
- Channel 3 is reserved. Its input is tied inactive.
- Channel 5 reacts to the falling edge of the memory-busy line. It gets this by taking the opposite edge of a fixed rising-edge detector, which has the same effect as inverting the line.
- Channel 6 is driven by an internal tick generator, which drops its output once every `TICK_CYCLES` clocks. This channel also has a nested tick flag and tick enable in the register at 0xE8. An acknowledge does not clear the tick flag. Only software can clear it.

Software reaches all enables, flags and polarity bits through a small register port. Writes are synchronous. Reads are combinational.

Top module: `ext_irq_front`

## Requirements
- R1: While `rst_n` is low and after it is released, all flags, enables, polarity bits, the tick enable and the tick flag are 0, so `irq_req` is 0 and every register reads 0.
- R2: When an input pin changes before clock edge k, the resulting flag is set by edge k+2 and not earlier.
- R3: Channel 0 and channel 1 set on a rising edge of their pins. Channel 4 sets on a rising edge of `cmp_in`.
- R4: Polarity register 0xC8 controls two channels. Bit 0 selects channel 2 and bit 1 selects channel 3, where 1 means falling edge and 0 means rising edge. Channel 2 uses `cmp_in`. Channel 3 never sets.
- R5: Channel 5 sets on a falling edge of `eep_busy_in`. A rising edge has no effect.
- R6: Flags set whether or not the channel is enabled. `irq_req[i]` is high exactly when flag i and enable bit i (register 0xA8, bit i) are both 1. For channel 6 the tick enable must also be 1.
- R7: An acknowledge (`ack_valid` with `ack_id` = i, for i from 0 to 6) clears flag i on that edge.
- R8: If a flag's edge event falls on the same clock edge as a clear of that flag, the flag ends up set.
- R9: The tick generator makes one event every `TICK_CYCLES` clocks. The event sets both the channel 6 flag and the tick flag. Setting the tick enable to 0 masks `irq_req[6]`.
- R10: Register 0xE8 holds the tick enable in bit 0 and the tick flag in bit 1. An acknowledge never clears the tick flag. Writing 1 to bit 1 clears it and leaves the channel 6 flag untouched.
- R11: Flag register 0xC0 is read/write-1-to-clear. Bit i is channel i.
- R12: Enable register 0xA8 and polarity register 0xC8 read back the values written to them. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dio_hp_in | input | 1 | Raw request line for channel 0 |
| dio_lp_in | input | 1 | Raw request line for channel 1 |
| cmp_in | input | 1 | Raw comparator output, feeds channels 2 and 4 |
| eep_busy_in | input | 1 | Raw memory-busy line, feeds channel 5 |
| ack_valid | input | 1 | Core acknowledges an interrupt this cycle |
| ack_id | input | 3 | Channel being acknowledged |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_req | output | 7 | Per-channel request to the core |

## Verification
A flag or enable holding the wrong value shows up on `irq_req` in the same cycle. It also shows up on `reg_rdata` as soon as the register is addressed. An edge detector with a wrong synchronizer depth or the wrong direction moves or loses a flag set, and the mismatch appears within three clocks of the pin change. A tick counter with the wrong modulus shifts the channel 6 request by whole cycles against a model that counts edges since reset. The bench therefore compares both outputs with its model on every clock.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants for the external interrupt front end.
// Assumes a fixed seven-channel wiring and an 8-bit register port.
package ext_irq_pkg;
    localparam int NCH  = 7;
    localparam int IDW  = 3;
    localparam int AW   = 8;
    localparam int DW   = 8;
    localparam int TICK_CH = NCH - 1;

    localparam logic [AW-1:0] ADDR_EN   = 8'hA8;
    localparam logic [AW-1:0] ADDR_FLAG = 8'hC0;
    localparam logic [AW-1:0] ADDR_POL  = 8'hC8;
    localparam logic [AW-1:0] ADDR_TICK = 8'hE8;

    typedef logic [NCH-1:0] ch_vec_t;
endpackage

// File: rtl/irq_edge_det.sv
`timescale 1ns/1ps
// Synchronizes one raw line (SYNC_STAGES flops, 0 = already in clock domain),
// then reports a single-cycle hit on the edge chosen by fall_sel
// (1 = falling, 0 = rising). All flops reset to 0, so an idle-low line
// gives no event after reset.
module irq_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic fall_sel,
    output logic hit
);
    logic cur;
    logic prev;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            // shift raw input through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain[0] <= din;
                    for (int k = 1; k < SYNC_STAGES; k++) begin
                        chain[k] <= chain[k-1];
                    end
                end
            end
            assign cur = chain[SYNC_STAGES-1];
        end else begin : g_direct
            assign cur = din;
        end
    endgenerate

    // hold previous synchronized sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= cur;
    end

    assign hit = fall_sel ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/irq_tick_gen.sv
`timescale 1ns/1ps
// Free-running divider: output is high for the last cycle of each
// TICK_CYCLES-long period and drops at the wrap. Assumes TICK_CYCLES >= 2.
module irq_tick_gen #(
    parameter int TICK_CYCLES = 27965
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt;

    // count clocks modulo TICK_CYCLES
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/ext_irq_front.sv
`timescale 1ns/1ps
// External interrupt front end: per-channel edge detection, pending flags,
// enables, acknowledge clear, and a nested tick flag on the last channel.
// Assumes one clock domain for core and registers; raw pins are asynchronous.
module ext_irq_front
    import ext_irq_pkg::*;
#(
    parameter int TICK_CYCLES = 27965,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dio_hp_in,
    input  logic          dio_lp_in,
    input  logic          cmp_in,
    input  logic          eep_busy_in,
    input  logic          ack_valid,
    input  logic [IDW-1:0] ack_id,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [NCH-1:0] irq_req
);
    localparam int NPIN = NCH - 1;

    ch_vec_t     flag_q;
    ch_vec_t     en_q;
    ch_vec_t     edge_hit;
    ch_vec_t     ack_dec;
    ch_vec_t     sw_clr;
    logic [1:0]  pol_q;
    logic        tick_en_q;
    logic        tick_flag_q;
    logic        tick;
    logic        wdata_unused;

    logic [NPIN-1:0] pin_raw;
    logic [NPIN-1:0] pin_fall;

    // pin routing; channel 3 reserved and tied low
    assign pin_raw  = {eep_busy_in, cmp_in, 1'b0, cmp_in, dio_lp_in, dio_hp_in};
    // busy line is taken on its falling edge (inverted rising detector)
    assign pin_fall = {1'b1, 1'b0, pol_q[1], pol_q[0], 1'b0, 1'b0};

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_pin
            irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
                .clk      (clk),
                .rst_n    (rst_n),
                .din      (pin_raw[g]),
                .fall_sel (pin_fall[g]),
                .hit      (edge_hit[g])
            );
        end
    endgenerate

    irq_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // tick is already synchronous; act on its falling edge
    irq_edge_det #(.SYNC_STAGES(0)) u_tick_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (tick),
        .fall_sel (1'b1),
        .hit      (edge_hit[TICK_CH])
    );

    // decode acknowledge and software clear strobes
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ack_dec[i] = ack_valid && (ack_id == IDW'(i));
            sw_clr[i]  = reg_we && (reg_addr == ADDR_FLAG) && reg_wdata[i];
        end
    end

    // pending flags: an edge outranks any clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (edge_hit[i])                 flag_q[i] <= 1'b1;
                else if (ack_dec[i] || sw_clr[i]) flag_q[i] <= 1'b0;
            end
        end
    end

    // control registers: enables, polarity, tick enable and tick flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= '0;
            pol_q       <= '0;
            tick_en_q   <= 1'b0;
            tick_flag_q <= 1'b0;
        end else begin
            if (reg_we && reg_addr == ADDR_EN)  en_q  <= reg_wdata[NCH-1:0];
            if (reg_we && reg_addr == ADDR_POL) pol_q <= reg_wdata[1:0];
            if (reg_we && reg_addr == ADDR_TICK) tick_en_q <= reg_wdata[0];
            if (edge_hit[TICK_CH])
                tick_flag_q <= 1'b1;
            else if (reg_we && reg_addr == ADDR_TICK && reg_wdata[1])
                tick_flag_q <= 1'b0;
        end
    end

    // request gating; last channel also needs the tick enable
    assign irq_req = flag_q & en_q & {tick_en_q, {(NCH-1){1'b1}}};

    // combinational register read mux
    always_comb begin
        case (reg_addr)
            ADDR_EN:   reg_rdata = {{(DW-NCH){1'b0}}, en_q};
            ADDR_FLAG: reg_rdata = {{(DW-NCH){1'b0}}, flag_q};
            ADDR_POL:  reg_rdata = {{(DW-2){1'b0}}, pol_q};
            ADDR_TICK: reg_rdata = {{(DW-2){1'b0}}, tick_flag_q, tick_en_q};
            default:   reg_rdata = '0;
        endcase
    end

    assign wdata_unused = reg_wdata[DW-1];
endmodule

// File: rtl/ext_irq_front_chk.sv
`timescale 1ns/1ps
// Assertion checker bound into ext_irq_front; observes ports and flag state.
module ext_irq_front_chk
    import ext_irq_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input ch_vec_t        flag_q,
    input ch_vec_t        en_q,
    input ch_vec_t        edge_hit,
    input logic           tick_flag_q,
    input logic           ack_valid,
    input logic [IDW-1:0] ack_id,
    input logic           reg_we,
    input logic [AW-1:0]  reg_addr,
    input logic [DW-1:0]  reg_wdata,
    input logic [NCH-1:0] irq_req
);
    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            // R8
            edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                edge_hit[g] |=> flag_q[g]);

            // R2
            no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_q[g]) |-> $past(edge_hit[g]));

            // R6
            req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_req[g] |-> en_q[g]);

            // R7
            ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_valid && ack_id == IDW'(g) && !edge_hit[g]
                 && !(reg_we && reg_addr == ADDR_FLAG && reg_wdata[g] == 1'b0 && 1'b0))
                |=> !flag_q[g]);
        end
    endgenerate

    // R10
    tick_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_flag_q && !(reg_we && reg_addr == ADDR_TICK && reg_wdata[1]))
        |=> tick_flag_q);
endmodule

bind ext_irq_front ext_irq_front_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_q      (flag_q),
    .en_q        (en_q),
    .edge_hit    (edge_hit),
    .tick_flag_q (tick_flag_q),
    .ack_valid   (ack_valid),
    .ack_id      (ack_id),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .irq_req     (irq_req)
);

// File: tb/ext_irq_front_tb.sv
`timescale 1ns/1ps
module ext_irq_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICKS = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dio_hp_in = 1'b0, dio_lp_in = 1'b0, cmp_in = 1'b0, eep_busy_in = 1'b0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_id = 3'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [6:0] irq_req;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    ext_irq_front #(.TICK_CYCLES(TICKS), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .dio_hp_in(dio_hp_in), .dio_lp_in(dio_lp_in),
        .cmp_in(cmp_in), .eep_busy_in(eep_busy_in), .ack_valid(ack_valid),
        .ack_id(ack_id), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [6:0] m_en, m_flag;
    logic [1:0] m_pol;
    logic       m_ten, m_tflag;
    logic [3:0] h0, h1, h2;
    int         ecount;

    always @(posedge clk) begin
        logic [3:0] rise, fall;
        logic [6:0] ev;
        if (!rst_n) begin
            m_en = '0; m_flag = '0; m_pol = '0; m_ten = 0; m_tflag = 0;
            h0 = '0; h1 = '0; h2 = '0; ecount = 0;
        end else begin
            ecount++;
            rise = h1 & ~h2;
            fall = ~h1 & h2;
            ev[0] = rise[0];
            ev[1] = rise[1];
            ev[2] = m_pol[0] ? fall[2] : rise[2];
            ev[3] = 1'b0;
            ev[4] = rise[2];
            ev[5] = fall[3];
            ev[6] = (ecount > 1) && (ecount % TICKS == 1);
            for (int i = 0; i < 7; i++) begin
                if (ev[i]) m_flag[i] = 1'b1;
                else if ((ack_valid && ack_id == 3'(i)) ||
                         (reg_we && reg_addr == 8'hC0 && reg_wdata[i])) m_flag[i] = 1'b0;
            end
            if (ev[6]) m_tflag = 1'b1;
            else if (reg_we && reg_addr == 8'hE8 && reg_wdata[1]) m_tflag = 1'b0;
            if (reg_we && reg_addr == 8'hA8) m_en = reg_wdata[6:0];
            if (reg_we && reg_addr == 8'hC8) m_pol = reg_wdata[1:0];
            if (reg_we && reg_addr == 8'hE8) m_ten = reg_wdata[0];
            h2 = h1; h1 = h0; h0 = {eep_busy_in, cmp_in, dio_lp_in, dio_hp_in};
        end
    end

    // per-cycle comparison, a quarter period after the edge
    always @(posedge clk) begin
        logic [6:0] er;
        logic [7:0] ed;
        #(CLK_PERIOD/4);
        if (rst_n) begin
            er = m_flag & m_en & {m_ten, 6'h3F};
            case (reg_addr)
                8'hA8: ed = {1'b0, m_en};
                8'hC0: ed = {1'b0, m_flag};
                8'hC8: ed = {6'b0, m_pol};
                8'hE8: ed = {6'b0, m_tflag, m_ten};
                default: ed = 8'h00;
            endcase
            checks += 2;
            if (irq_req !== er) begin
                errors++;
                $display("FAIL %s model irq_req act %b exp %b", phase, irq_req, er);
            end
            if (reg_rdata !== ed) begin
                errors++;
                $display("FAIL %s model rdata @%h act %h exp %h", phase, reg_addr, reg_rdata, ed);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic ack(input int id);
        ack_valid = 1'b1; ack_id = 3'(id);
        step(1);
        ack_valid = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] mask,
                          input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata & mask, exp);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act running exp done");
        finish_run();
    end

    initial begin
        int n;
        step(4);
        // R1: reset state
        chk("R1 irq_req", {1'b0, irq_req}, 8'h00);
        rd_chk("R1 en", 8'hA8, 8'hFF, 8'h00);
        rd_chk("R1 flag", 8'hC0, 8'hFF, 8'h00);
        rd_chk("R1 pol", 8'hC8, 8'hFF, 8'h00);
        rd_chk("R1 tick", 8'hE8, 8'hFF, 8'h00);
        rst_n = 1'b1;
        step(1);
        phase = "R12";
        wr(8'hA8, 8'h7F);
        wr(8'hC8, 8'h01);
        wr(8'hE8, 8'h01);
        rd_chk("R12 en", 8'hA8, 8'hFF, 8'h7F);
        rd_chk("R12 pol", 8'hC8, 8'hFF, 8'h01);
        rd_chk("R12 unmapped", 8'h55, 8'hFF, 8'h00);
        reg_addr = 8'hC0;
        // R2: two-stage latency
        phase = "R2";
        dio_hp_in = 1'b1;
        step(2);
        chk("R2 early", {7'b0, irq_req[0]}, 8'h00);
        step(1);
        chk("R2 on time", {7'b0, irq_req[0]}, 8'h01);
        phase = "R7";
        ack(0);
        chk("R7 ack clear", {7'b0, irq_req[0]}, 8'h00);
        // R3: rising channels
        phase = "R3";
        dio_lp_in = 1'b1; step(3);
        chk("R3 ch1", {7'b0, irq_req[1]}, 8'h01);
        cmp_in = 1'b1; step(3);
        chk("R3 ch4 rise", {7'b0, irq_req[4]}, 8'h01);
        chk("R4 ch2 ignores rise", {7'b0, irq_req[2]}, 8'h00);
        phase = "R4";
        cmp_in = 1'b0; step(3);
        chk("R4 ch2 fall", {7'b0, irq_req[2]}, 8'h01);
        chk("R4 ch3 idle", {7'b0, irq_req[3]}, 8'h00);
        ack(1); ack(2); ack(4);
        wr(8'hC8, 8'h02);
        cmp_in = 1'b1; step(3);
        chk("R4 ch2 rise mode", {7'b0, irq_req[2]}, 8'h01);
        chk("R4 ch3 never", {7'b0, irq_req[3]}, 8'h00);
        ack(2); ack(4);
        cmp_in = 1'b0; step(3);
        chk("R4 ch2 fall ignored", {7'b0, irq_req[2]}, 8'h00);
        // R5: busy falling edge
        phase = "R5";
        eep_busy_in = 1'b1; step(3);
        chk("R5 rise ignored", {7'b0, irq_req[5]}, 8'h00);
        eep_busy_in = 1'b0; step(3);
        chk("R5 fall sets", {7'b0, irq_req[5]}, 8'h01);
        ack(5);
        // R6: flag sets while disabled
        phase = "R6";
        wr(8'hA8, 8'h00);
        dio_hp_in = 1'b0; step(3);
        dio_hp_in = 1'b1; step(3);
        chk("R6 masked", {7'b0, irq_req[0]}, 8'h00);
        rd_chk("R6 flag", 8'hC0, 8'h01, 8'h01);
        wr(8'hA8, 8'h7F);
        chk("R6 unmasked", {7'b0, irq_req[0]}, 8'h01);
        // R11: write-one-to-clear
        phase = "R11";
        wr(8'hC0, 8'h3F);
        rd_chk("R11 cleared", 8'hC0, 8'h3F, 8'h00);
        // R8: edge beats ack
        phase = "R8";
        dio_hp_in = 1'b0; step(3);
        dio_hp_in = 1'b1; step(2);
        ack_valid = 1'b1; ack_id = 3'd0;
        step(1);
        ack_valid = 1'b0;
        chk("R8 edge wins", {7'b0, irq_req[0]}, 8'h01);
        ack(0);
        // R9: tick period and flags
        phase = "R9";
        ack(6);
        wr(8'hE8, 8'h03);
        n = 0;
        while (!irq_req[6] && n < 200) begin step(1); n++; end
        rd_chk("R9 tick flag", 8'hE8, 8'h02, 8'h02);
        ack(6);
        chk("R7 ch6 ack", {7'b0, irq_req[6]}, 8'h00);
        rd_chk("R10 ack keeps sub flag", 8'hE8, 8'h02, 8'h02);
        n = 1;
        while (!irq_req[6] && n < 200) begin step(1); n++; end
        chk("R9 period", 8'(n), 8'(TICKS));
        phase = "R10";
        wr(8'hE8, 8'h03);
        rd_chk("R10 sw clear", 8'hE8, 8'h03, 8'h01);
        chk("R10 ch6 kept", {7'b0, irq_req[6]}, 8'h01);
        phase = "R9";
        wr(8'hE8, 8'h00);
        chk("R9 tick enable masks", {7'b0, irq_req[6]}, 8'h00);
        step(5);
        finish_run();
    end
endmodule